// File: doc/BRIEF.md
# Out-of-Order Issue Tracker with In-Order Graduation

This block keeps the bookkeeping for a small out-of-order core model, cycle by cycle. Decoded instructions arrive in program order. Each one names an operation class (load, add or multiply), one logical destination register and one logical source register. The tracker gives each instruction a fresh physical destination register and points its source at the physical register that produces the value. The instruction then waits in an eight-entry window.

An instruction leaves the window for execution once two conditions hold: its source value has been produced, and the single non-pipelined unit of its class is idle. When several instructions qualify, the oldest one goes. Each class has a fixed latency, so completions can arrive out of program order. Graduation still follows program order, driven by a head pointer that names the next sequence tag allowed to retire. When an instruction graduates, the physical register that held the previous value of its logical destination is released.

The block reports only timing and ordering: one-cycle strobes with 3-bit sequence tags for issue, per-class completion and graduation. No data values are computed.

Top module: `ooo_tracker`

## Requirements
- R1: After reset, every strobe output is low and `disp_ready` is high.
- R2: An instruction is accepted on a rising edge where `disp_valid` and `disp_ready` are both high. Accepted instructions get sequence tags 0, 1, 2, ... in acceptance order, wrapping modulo 8. All reported tags use this numbering.
- R3: At most 8 accepted, not yet graduated instructions are held. `disp_ready` is low exactly when 8 are held, and `disp_valid` is then ignored.
- R4: An instruction whose source register was last written by an older instruction does not issue before the edge after that producer's completion edge. A source with no pending producer is ready at once.
- R5: There is one unit per class. A unit stays busy from its issue edge until its completion edge, so the next issue to the same class comes no earlier than the edge after that completion.
- R6: At most one instruction issues per edge. Among the instructions eligible at an edge, the oldest in program order issues. The earliest possible issue is the edge after acceptance. `iss_valid` pulses in the cycle after the issue edge, with the tag on `iss_seq`.
- R7: Class codes are 0 = load, 1 = add, 2 = multiply, and code 3 is handled as add. The completion strobe follows the issue strobe by exactly 4 cycles for a load, 1 for an add and 2 for a multiply.
- R8: Completion is reported per class. Bit c of `cmp_valid` pulses for class c, and its tag sits in `cmp_seq[3c+2:3c]`. Several classes may complete in the same cycle and out of program order.
- R9: Graduation is strictly in tag order, at most one per cycle, and only for the oldest held instruction. That instruction graduates on the first edge after its completion edge. A younger completed instruction waits behind an incomplete older one.
- R10: Renaming removes false dependences. A later write to a register that an older waiting instruction reads, or already writes, does not delay that older instruction. A source equal to the instruction's own destination reads the older value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Decoded instruction offered |
| disp_cls | input | 2 | Operation class code |
| disp_dst | input | 3 | Logical destination register |
| disp_src | input | 3 | Logical source register |
| disp_ready | output | 1 | Window has room |
| iss_valid | output | 1 | Issue strobe |
| iss_seq | output | 3 | Tag of the issued instruction |
| cmp_valid | output | 3 | Completion strobe per class |
| cmp_seq | output | 9 | Completion tags, 3 bits per class |
| grad_valid | output | 1 | Graduation strobe |
| grad_seq | output | 3 | Tag of the graduated instruction |

## Verification
On every cycle, the assertions check the internal consistency of the tracker:
- a unit is never started while it is still counting;
- a completion always targets a live, issued, unfinished window entry, and its physical register is still pending;
- a released register is neither free nor pending;
- allocation never finds the free pool empty;
- the window count never exceeds its depth.

Only the bench's cycle-exact reference model shows the timing and ordering behaviour. This covers oldest-first selection, the exact latency from issue to completion, the wait on true dependences only, and graduation stalls behind a slow older load. The model predicts every strobe and tag under directed sequences and random traffic.

// File: rtl/ooo_pkg.sv
package ooo_pkg;
  typedef enum logic [1:0] {
    CLS_LOAD = 2'd0,
    CLS_ADD  = 2'd1,
    CLS_MUL  = 2'd2,
    CLS_RSVD = 2'd3
  } op_cls_e;

  localparam int NUM_CLS = 3;
  localparam int CLSW    = 2;

  // Reserved code 3 executes on the add unit (R7)
  function automatic logic [CLSW-1:0] unit_of(input logic [CLSW-1:0] code);
    return (code == CLS_RSVD) ? CLS_ADD : code;
  endfunction
endpackage

// File: rtl/ooo_fu.sv
module ooo_fu #(
  parameter int LAT   = 1,
  parameter int TAGW  = 3,
  parameter int PREGW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [TAGW-1:0]  seq_i,
  input  logic [PREGW-1:0] pdst_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic [TAGW-1:0]  seq_o,
  output logic [PREGW-1:0] pdst_o
);
  localparam int CNTW = $clog2(LAT + 1);

  logic [CNTW-1:0]  cnt_q;
  logic [TAGW-1:0]  seq_q;
  logic [PREGW-1:0] pdst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      seq_q  <= '0;
      pdst_q <= '0;
    end else if (start_i) begin
      cnt_q  <= CNTW'(LAT);
      seq_q  <= seq_i;
      pdst_q <= pdst_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign fin_o  = (cnt_q == CNTW'(1));
  assign seq_o  = seq_q;
  assign pdst_o = pdst_q;

  // R5: a unit is never restarted while still counting
  p_unit_idle_at_start_r5: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (cnt_q == '0));
endmodule

// File: rtl/ooo_rename.sv
module ooo_rename
  import ooo_pkg::*;
#(
  parameter int NLREG = 8,
  parameter int NPREG = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc_i,
  input  logic [$clog2(NLREG)-1:0] dst_i,
  input  logic [$clog2(NLREG)-1:0] src_i,
  output logic [$clog2(NPREG)-1:0] new_preg_o,
  output logic [$clog2(NPREG)-1:0] src_preg_o,
  output logic [$clog2(NPREG)-1:0] old_preg_o,
  output logic [NPREG-1:0]         busy_o,
  input  logic [NUM_CLS-1:0]       wb_valid_i,
  input  logic [NUM_CLS*$clog2(NPREG)-1:0] wb_preg_i,
  input  logic                     rel_i,
  input  logic [$clog2(NPREG)-1:0] rel_preg_i
);
  localparam int PREGW = $clog2(NPREG);

  logic [PREGW-1:0] map_q [NLREG];
  logic [NPREG-1:0] free_q, free_d;
  logic [NPREG-1:0] busy_q, busy_d;
  logic [PREGW-1:0] pick;
  logic             found;

  // lowest-numbered free physical register
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int p = 0; p < NPREG; p++) begin
      if (!found && free_q[p]) begin
        pick  = PREGW'(p);
        found = 1'b1;
      end
    end
  end

  assign new_preg_o = pick;
  assign src_preg_o = map_q[src_i];
  assign old_preg_o = map_q[dst_i];
  assign busy_o     = busy_q;

  always_comb begin
    free_d = free_q;
    busy_d = busy_q;
    for (int c = 0; c < NUM_CLS; c++) begin
      if (wb_valid_i[c]) busy_d[wb_preg_i[c*PREGW +: PREGW]] = 1'b0;
    end
    if (rel_i) free_d[rel_preg_i] = 1'b1;
    if (alloc_i) begin
      free_d[pick] = 1'b0;
      busy_d[pick] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLREG; i++) map_q[i] <= PREGW'(i);
      for (int p = 0; p < NPREG; p++) free_q[p] <= (p >= NLREG);
      busy_q <= '0;
    end else begin
      if (alloc_i) map_q[dst_i] <= pick;
      free_q <= free_d;
      busy_q <= busy_d;
    end
  end

  // R3: the pool never runs dry while the window accepts
  p_alloc_has_free_r3: assert property (@(posedge clk) disable iff (rst)
    alloc_i |-> (free_q != '0));

  // R10: a released register was in use and already written
  p_release_in_use_r10: assert property (@(posedge clk) disable iff (rst)
    rel_i |-> (!free_q[rel_preg_i] && !busy_q[rel_preg_i]));

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_wbchk
    // R8: a completion writes a register that is still pending
    p_wb_was_pending_r8: assert property (@(posedge clk) disable iff (rst)
      wb_valid_i[c] |-> busy_q[wb_preg_i[c*PREGW +: PREGW]]);
  end
endmodule

// File: rtl/ooo_window.sv
module ooo_window
  import ooo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NPREG = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      disp_valid_i,
  input  logic [CLSW-1:0]           disp_unit_i,
  input  logic [$clog2(NPREG)-1:0]  psrc_i,
  input  logic [$clog2(NPREG)-1:0]  pdst_i,
  input  logic [$clog2(NPREG)-1:0]  pold_i,
  input  logic [NPREG-1:0]          busy_i,
  input  logic [NUM_CLS-1:0]        unit_busy_i,
  input  logic [NUM_CLS-1:0]        fin_i,
  input  logic [NUM_CLS*$clog2(DEPTH)-1:0] fin_seq_i,
  output logic                      disp_ready_o,
  output logic                      alloc_o,
  output logic [$clog2(DEPTH)-1:0]  tail_o,
  output logic                      iss_fire_o,
  output logic [$clog2(DEPTH)-1:0]  iss_seq_o,
  output logic [CLSW-1:0]           iss_unit_o,
  output logic [$clog2(NPREG)-1:0]  iss_pdst_o,
  output logic                      grad_fire_o,
  output logic [$clog2(DEPTH)-1:0]  grad_seq_o,
  output logic [$clog2(NPREG)-1:0]  grad_pold_o
);
  localparam int TAGW  = $clog2(DEPTH);
  localparam int PREGW = $clog2(NPREG);
  localparam int CNTW  = TAGW + 1;

  logic [DEPTH-1:0] ent_v, ent_iss, ent_done;
  logic [CLSW-1:0]  ent_unit [DEPTH];
  logic [PREGW-1:0] ent_psrc [DEPTH];
  logic [PREGW-1:0] ent_pdst [DEPTH];
  logic [PREGW-1:0] ent_pold [DEPTH];
  logic [TAGW-1:0]  head_q, tail_q;
  logic [CNTW-1:0]  cnt_q;
  logic [TAGW-1:0]  sel_idx, idx;
  logic             sel_fire;

  assign disp_ready_o = (cnt_q < CNTW'(DEPTH));
  assign alloc_o      = disp_valid_i && disp_ready_o;
  assign tail_o       = tail_q;

  // oldest eligible entry, scanning from the head
  always_comb begin
    sel_fire = 1'b0;
    sel_idx  = '0;
    idx      = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_q + TAGW'(k);
      if (!sel_fire && ent_v[idx] && !ent_iss[idx] &&
          !busy_i[ent_psrc[idx]] && !unit_busy_i[ent_unit[idx]]) begin
        sel_fire = 1'b1;
        sel_idx  = idx;
      end
    end
  end

  assign iss_fire_o  = sel_fire;
  assign iss_seq_o   = sel_idx;
  assign iss_unit_o  = ent_unit[sel_idx];
  assign iss_pdst_o  = ent_pdst[sel_idx];
  assign grad_fire_o = ent_v[head_q] && ent_done[head_q];
  assign grad_seq_o  = head_q;
  assign grad_pold_o = ent_pold[head_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v    <= '0;
      ent_iss  <= '0;
      ent_done <= '0;
      head_q   <= '0;
      tail_q   <= '0;
      cnt_q    <= '0;
    end else begin
      if (alloc_o) begin
        ent_v[tail_q]    <= 1'b1;
        ent_iss[tail_q]  <= 1'b0;
        ent_done[tail_q] <= 1'b0;
        tail_q           <= tail_q + 1'b1;
      end
      if (sel_fire) ent_iss[sel_idx] <= 1'b1;
      for (int c = 0; c < NUM_CLS; c++) begin
        if (fin_i[c]) ent_done[fin_seq_i[c*TAGW +: TAGW]] <= 1'b1;
      end
      if (grad_fire_o) begin
        ent_v[head_q] <= 1'b0;
        head_q        <= head_q + 1'b1;
      end
      case ({alloc_o, grad_fire_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // payload fields: plain write port, no reset
  always_ff @(posedge clk) begin
    if (alloc_o) begin
      ent_unit[tail_q] <= disp_unit_i;
      ent_psrc[tail_q] <= psrc_i;
      ent_pdst[tail_q] <= pdst_i;
      ent_pold[tail_q] <= pold_i;
    end
  end

  // R3: occupancy bounded by the window depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNTW'(DEPTH));

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_finchk
    // R8: a completion lands on a live, issued, unfinished entry
    p_fin_target_live_r8: assert property (@(posedge clk) disable iff (rst)
      fin_i[c] |-> (ent_v[fin_seq_i[c*TAGW +: TAGW]] &&
                    ent_iss[fin_seq_i[c*TAGW +: TAGW]] &&
                    !ent_done[fin_seq_i[c*TAGW +: TAGW]]));
  end
endmodule

// File: rtl/ooo_tracker.sv
module ooo_tracker
  import ooo_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int NLREG    = 8,
  parameter int LAT_LOAD = 4,
  parameter int LAT_ADD  = 1,
  parameter int LAT_MUL  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        disp_valid,
  input  logic [1:0]                  disp_cls,
  input  logic [$clog2(NLREG)-1:0]    disp_dst,
  input  logic [$clog2(NLREG)-1:0]    disp_src,
  output logic                        disp_ready,
  output logic                        iss_valid,
  output logic [$clog2(DEPTH)-1:0]    iss_seq,
  output logic [2:0]                  cmp_valid,
  output logic [3*$clog2(DEPTH)-1:0]  cmp_seq,
  output logic                        grad_valid,
  output logic [$clog2(DEPTH)-1:0]    grad_seq
);
  localparam int TAGW  = $clog2(DEPTH);
  localparam int NPREG = NLREG + DEPTH;
  localparam int PREGW = $clog2(NPREG);

  logic                      alloc;
  logic [TAGW-1:0]           tail;
  logic [PREGW-1:0]          new_preg, src_preg, old_preg;
  logic [NPREG-1:0]          preg_busy;
  logic                      iss_fire, grad_fire;
  logic [TAGW-1:0]           iss_tag, grad_tag;
  logic [CLSW-1:0]           iss_unit;
  logic [PREGW-1:0]          iss_pdst, grad_pold;
  logic [NUM_CLS-1:0]        fu_busy, fu_fin;
  logic [NUM_CLS*TAGW-1:0]   fu_seq;
  logic [NUM_CLS*PREGW-1:0]  fu_pdst;

  ooo_rename #(.NLREG(NLREG), .NPREG(NPREG)) u_rename (
    .clk        (clk),
    .rst        (rst),
    .alloc_i    (alloc),
    .dst_i      (disp_dst),
    .src_i      (disp_src),
    .new_preg_o (new_preg),
    .src_preg_o (src_preg),
    .old_preg_o (old_preg),
    .busy_o     (preg_busy),
    .wb_valid_i (fu_fin),
    .wb_preg_i  (fu_pdst),
    .rel_i      (grad_fire),
    .rel_preg_i (grad_pold)
  );

  ooo_window #(.DEPTH(DEPTH), .NPREG(NPREG)) u_window (
    .clk          (clk),
    .rst          (rst),
    .disp_valid_i (disp_valid),
    .disp_unit_i  (unit_of(disp_cls)),
    .psrc_i       (src_preg),
    .pdst_i       (new_preg),
    .pold_i       (old_preg),
    .busy_i       (preg_busy),
    .unit_busy_i  (fu_busy),
    .fin_i        (fu_fin),
    .fin_seq_i    (fu_seq),
    .disp_ready_o (disp_ready),
    .alloc_o      (alloc),
    .tail_o       (tail),
    .iss_fire_o   (iss_fire),
    .iss_seq_o    (iss_tag),
    .iss_unit_o   (iss_unit),
    .iss_pdst_o   (iss_pdst),
    .grad_fire_o  (grad_fire),
    .grad_seq_o   (grad_tag),
    .grad_pold_o  (grad_pold)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_unit
    localparam int LAT = (c == int'(CLS_LOAD)) ? LAT_LOAD :
                         (c == int'(CLS_ADD))  ? LAT_ADD  : LAT_MUL;
    ooo_fu #(.LAT(LAT), .TAGW(TAGW), .PREGW(PREGW)) u_fu (
      .clk     (clk),
      .rst     (rst),
      .start_i (iss_fire && (iss_unit == CLSW'(c))),
      .seq_i   (iss_tag),
      .pdst_i  (iss_pdst),
      .busy_o  (fu_busy[c]),
      .fin_o   (fu_fin[c]),
      .seq_o   (fu_seq[c*TAGW +: TAGW]),
      .pdst_o  (fu_pdst[c*PREGW +: PREGW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid  <= 1'b0;
      iss_seq    <= '0;
      cmp_valid  <= '0;
      cmp_seq    <= '0;
      grad_valid <= 1'b0;
      grad_seq   <= '0;
    end else begin
      iss_valid  <= iss_fire;
      iss_seq    <= iss_tag;
      cmp_valid  <= fu_fin;
      cmp_seq    <= fu_seq;
      grad_valid <= grad_fire;
      grad_seq   <= grad_tag;
    end
  end

  // R2: a new entry is written only into a slot that is not live
  p_alloc_tail_free_r2: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !(grad_fire && (grad_tag == tail)));
endmodule

// File: tb/sim_ooo_tracker.sv
module sim_ooo_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int MAXN  = 2048;

  logic clk = 1'b0;
  logic rst;
  logic disp_valid;
  logic [1:0] disp_cls;
  logic [2:0] disp_dst, disp_src;
  logic disp_ready, iss_valid, grad_valid;
  logic [2:0] iss_seq, grad_seq, cmp_valid;
  logic [8:0] cmp_seq;

  ooo_tracker u0 (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_cls(disp_cls),
    .disp_dst(disp_dst), .disp_src(disp_src), .disp_ready(disp_ready),
    .iss_valid(iss_valid), .iss_seq(iss_seq), .cmp_valid(cmp_valid),
    .cmp_seq(cmp_seq), .grad_valid(grad_valid), .grad_seq(grad_seq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;
  int seen_full = 0;

  // reference model state, indexed by global instruction number
  int m_unit [MAXN];
  int m_prod [MAXN];
  bit m_iss  [MAXN];
  bit m_done [MAXN];
  int last_wr [8];
  int head_g = 0, tail_g = 0;
  int ucnt [3];
  int uinst [3];
  bit e_iss = 0, e_grad = 0;
  int e_iss_g = 0, e_grad_g = 0;
  bit e_cmp [3];
  int e_cmp_g [3];

  function automatic int lat_of(input int u);
    return (u == 0) ? 4 : (u == 1) ? 1 : 2;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_outputs();
    check(iss_valid == e_iss, "R6", "iss_valid", iss_valid, e_iss);
    if (e_iss) check(iss_seq == 3'(e_iss_g), "R6", "iss_seq", iss_seq, e_iss_g % 8);
    for (int c = 0; c < 3; c++) begin
      check(cmp_valid[c] == e_cmp[c], "R7", "cmp_valid", cmp_valid[c], e_cmp[c]);
      if (e_cmp[c])
        check(cmp_seq[c*3 +: 3] == 3'(e_cmp_g[c]), "R8", "cmp_seq",
              cmp_seq[c*3 +: 3], e_cmp_g[c] % 8);
    end
    check(grad_valid == e_grad, "R9", "grad_valid", grad_valid, e_grad);
    if (e_grad) check(grad_seq == 3'(e_grad_g), "R9", "grad_seq", grad_seq, e_grad_g % 8);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit v, input int cls, input int dst, input int src);
    bit acc, g, rdy;
    int iss;
    rdy = (tail_g - head_g) < DEPTH;
    check(disp_ready == rdy, "R3", "disp_ready", disp_ready, rdy);
    if (!rdy) seen_full++;
    if (tail_g >= MAXN - 1) v = 0;
    acc = v && rdy;
    disp_valid = v;
    disp_cls = 2'(cls);
    disp_dst = 3'(dst);
    disp_src = 3'(src);
    iss = -1;
    for (int gi = head_g; gi < tail_g; gi++) begin
      if (!m_iss[gi] && (m_prod[gi] < 0 || m_done[m_prod[gi]]) &&
          ucnt[m_unit[gi]] == 0) begin
        iss = gi;
        break;
      end
    end
    g = (head_g < tail_g) && m_done[head_g];
    @(posedge clk);
    for (int c = 0; c < 3; c++) begin
      e_cmp[c] = 0;
      if (ucnt[c] > 0) begin
        ucnt[c]--;
        if (ucnt[c] == 0) begin
          m_done[uinst[c]] = 1;
          e_cmp[c] = 1;
          e_cmp_g[c] = uinst[c];
        end
      end
    end
    e_iss = (iss >= 0);
    if (iss >= 0) begin
      m_iss[iss] = 1;
      ucnt[m_unit[iss]] = lat_of(m_unit[iss]);
      uinst[m_unit[iss]] = iss;
      e_iss_g = iss;
    end
    e_grad = g;
    if (g) begin
      e_grad_g = head_g;
      head_g++;
    end
    if (acc) begin
      m_unit[tail_g] = (cls == 3) ? 1 : cls;
      m_prod[tail_g] = last_wr[src];
      m_iss[tail_g]  = 0;
      m_done[tail_g] = 0;
      last_wr[dst]   = tail_g;
      tail_g++;
    end
    @(negedge clk);
    compare_outputs();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A17));
    for (int r = 0; r < 8; r++) last_wr[r] = -1;
    for (int c = 0; c < 3; c++) begin ucnt[c] = 0; uinst[c] = 0; e_cmp[c] = 0; e_cmp_g[c] = 0; end
    rst = 1'b1;
    disp_valid = 0; disp_cls = 0; disp_dst = 0; disp_src = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(disp_ready == 1'b1, "R1", "disp_ready", disp_ready, 1);
    check(iss_valid == 1'b0, "R1", "iss_valid", iss_valid, 0);
    check(cmp_valid == 3'b0, "R1", "cmp_valid", cmp_valid, 0);
    check(grad_valid == 1'b0, "R1", "grad_valid", grad_valid, 0);

    // R4/R9: load, mul, two dependent adds; graduation waits on the load
    step(1, 0, 2, 6);
    step(1, 2, 5, 5);   // R10: source equals own destination
    step(1, 1, 4, 2);
    step(1, 1, 5, 2);   // R10: rewrites r5 while the mul is in flight
    idle(20);

    // R5: independent adds and multiplies contend for their units
    for (int i = 0; i < 6; i++) step(1, (i % 2) ? 2 : 1, i, 7);
    idle(16);

    // R3: a chain of loads fills the window
    for (int i = 0; i < 14; i++) step(1, 0, 1, 1);
    check(seen_full > 0, "R3", "window full observed", seen_full, 1);
    idle(70);

    // R7: reserved class code runs as an add
    step(1, 3, 3, 0);
    step(1, 3, 3, 3);
    idle(8);

    // R6/R8: random traffic with varying density
    for (int ph = 0; ph < 6; ph++) begin
      int dens = 20 + ph * 15;
      for (int i = 0; i < 200; i++) begin
        bit v = ($urandom % 100) < dens;
        step(v, int'($urandom % 4), int'($urandom % 4), int'($urandom % 4));
      end
    end
    idle(80);
    check(head_g == tail_g, "R9", "all graduated", head_g, tail_g);
    check(disp_ready == 1'b1, "R3", "drained ready", disp_ready, 1);

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule